// File: doc/BRIEF.md
# NAND Transfer FIFO Engine

This block moves a programmed number of bytes between an 8-bit NAND data port and a 64-byte FIFO window on the host side. In the read direction it fetches bytes from the flash ahead of the host, and the host takes them out as 32-bit words. In the write direction the host posts 16-bit halfwords into the FIFO, and the engine writes them to the flash one byte at a time. NAND cycle timing is hidden behind a ready input and a per-byte strobe. The DMA controller is outside the block; the engine only raises a request level while a whole 64-byte frame can move.

A start command carries a chip select, a DMA flag, a byte length and a direction. The command is acknowledged when the engine is idle and refused when it is busy. A status word reports the busy flag, the FIFO byte count and the NAND-side bytes still to move. A stop pulse aborts the transfer, flushes the FIFO and returns the engine to idle.

The control state machine has four states. ST_IDLE waits for a command. ST_FETCH pulls bytes from the flash. ST_DRAIN waits for the host to empty the FIFO after the last fetch. ST_POST writes posted bytes to the flash. The transitions are:
- ST_IDLE to ST_FETCH on an accepted non-zero read.
- ST_IDLE to ST_POST on an accepted non-zero write.
- ST_FETCH to ST_DRAIN on the final fetch.
- ST_DRAIN to ST_IDLE on the word pop that empties the FIFO.
- ST_POST to ST_IDLE on the final NAND write.
- Any busy state to ST_IDLE on stop.

Top module: `nand_xfer_engine`

## Requirements
- R1: After reset the engine is idle: busy and dma_req are 0, status is 0, and neither NAND strobe is asserted.
- R2: A start while idle is accepted: start_ack pulses in the next cycle and, for a non-zero length, busy rises with status[13:0] equal to the length. A zero length is acknowledged and the engine stays idle.
- R3: A start while busy is refused: start_nak pulses in the next cycle, and the remaining count and chip select are unchanged.
- R4: Read (direction 0): bytes are fetched from the flash in order. A host_rd pops 4 bytes, returned little-endian (byte k of the word at bits 8k+7:8k). The pop happens only when at least 4 bytes are held; otherwise host_rd is ignored.
- R5: Read fetching stalls while the FIFO holds 64 bytes: nand_rd_strobe stays low until the host pops.
- R6: Write (direction 1): each accepted host_wr posts a halfword, and the low byte goes to the flash first. nand_wr_strobe is never asserted while the FIFO is empty. Halfwords beyond the programmed length are ignored.
- R7: status[31] is busy and status[13:0] is the remaining NAND-side byte count, which falls by one for each byte moved on the NAND side. status[30:24] is the number of bytes held in read mode, or the free space in write mode.
- R8: Busy clears only once the remaining count is zero and the FIFO is empty.
- R9: A stop while busy returns the engine to idle in the next cycle, with the FIFO flushed and the remaining count cleared.
- R10: dma_req is asserted only for a transfer started with the DMA flag. In read mode it requires at least 64 bytes held. In write mode it requires 64 bytes free with at least 64 bytes still to post.
- R11: nand_cs takes the chip select of the last accepted start and holds it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start command pulse |
| start_cs | input | 3 | Chip select for the command |
| start_dma | input | 1 | DMA pacing flag for the command |
| start_len | input | 14 | Transfer length in bytes |
| start_dir | input | 1 | Direction: 0 read, 1 write |
| stop | input | 1 | Abort and flush pulse |
| start_ack | output | 1 | Command accepted (one cycle after start) |
| start_nak | output | 1 | Command refused (one cycle after start) |
| busy | output | 1 | Transfer in progress |
| status | output | 32 | {busy, FIFO count[6:0], 10'b0, remaining[13:0]} |
| host_rd | input | 1 | Pop one 32-bit word |
| host_rd_data | output | 32 | Oldest four FIFO bytes, little-endian |
| host_wr | input | 1 | Post one 16-bit halfword |
| host_wr_data | input | 16 | Halfword to post |
| dma_req | output | 1 | Frame-ready request level for the DMA controller |
| nand_cs | output | 3 | Latched chip select |
| nand_rdy | input | 1 | NAND port can move a byte this cycle |
| nand_rd_strobe | output | 1 | A byte is read from the flash this cycle |
| nand_rd_data | input | 8 | Byte from the flash |
| nand_wr_strobe | output | 1 | A byte is written to the flash this cycle |
| nand_wr_data | output | 8 | Byte to the flash |

## Verification
The assertions assume that start, stop, host_rd and host_wr are driven only through the clocked interface, so that each cycle moves at most one NAND byte and one host unit. They also assume that the remaining count is never asked to fall below zero. The latter holds because the strobes stop once the final byte has moved. The bench drives every input at the falling edge, keeps read lengths a multiple of 4 and write lengths even except where it deliberately tests a leftover, and ends every leftover case with stop.

// File: rtl/nxe_pkg.sv
`timescale 1ns/1ps
package nxe_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_DRAIN = 2'd2,
        ST_POST  = 2'd3
    } nxe_state_e;
endpackage

// File: rtl/nxe_ring.sv
`timescale 1ns/1ps
module nxe_ring #(
    parameter int DEPTH = 64,
    parameter int LVL_W = $clog2(DEPTH) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic [1:0]       push_n,
    input  logic [15:0]      push_data,
    input  logic [2:0]       pop_n,
    output logic [31:0]      head,
    output logic [LVL_W-1:0] level
);
    localparam int AW = $clog2(DEPTH);

    logic [7:0]    mem [DEPTH];
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;

    always_ff @(posedge clk) begin
        if (push_n != 2'd0) mem[wr_ptr] <= push_data[7:0];
        if (push_n == 2'd2) mem[wr_ptr + AW'(1)] <= push_data[15:8];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else if (flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            wr_ptr <= wr_ptr + AW'(push_n);
            rd_ptr <= rd_ptr + AW'(pop_n);
            level  <= level + LVL_W'(push_n) - LVL_W'(pop_n);
        end
    end

    for (genvar k = 0; k < 4; k++) begin : g_head
        assign head[8*k +: 8] = mem[rd_ptr + AW'(k)];
    end
endmodule

// File: rtl/nxe_ctrl.sv
`timescale 1ns/1ps
module nxe_ctrl
    import nxe_pkg::*;
#(
    parameter int LEN_W = 14,
    parameter int CS_W  = 3,
    parameter int DEPTH = 64,
    parameter int LVL_W = $clog2(DEPTH) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CS_W-1:0]  start_cs,
    input  logic             start_dma,
    input  logic [LEN_W-1:0] start_len,
    input  logic             start_dir,
    input  logic             stop,
    input  logic             nand_rdy,
    input  logic             host_rd,
    input  logic             host_wr,
    input  logic [LVL_W-1:0] level,
    output nxe_state_e       state,
    output logic             busy,
    output logic             rd_strobe,
    output logic             wr_strobe,
    output logic [1:0]       push_n,
    output logic [2:0]       pop_n,
    output logic             flush,
    output logic [LEN_W-1:0] remaining,
    output logic [LEN_W-1:0] host_left,
    output logic             dir_q,
    output logic             dma_q,
    output logic [CS_W-1:0]  cs_q,
    output logic             start_ack,
    output logic             start_nak
);
    localparam logic [LVL_W-1:0] FULL = LVL_W'(DEPTH);

    nxe_state_e state_nx;
    logic       accept;
    logic       pop_ok;
    logic       push_ok;
    logic       last_byte;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        busy      = (state != ST_IDLE);
        accept    = start && !busy;
        rd_strobe = (state == ST_FETCH) && nand_rdy && (level < FULL);
        wr_strobe = (state == ST_POST) && nand_rdy && (level != '0);
        pop_ok    = ((state == ST_FETCH) || (state == ST_DRAIN)) && host_rd
                    && (level >= LVL_W'(4));
        push_ok   = (state == ST_POST) && host_wr && ((FULL - level) >= LVL_W'(2))
                    && (host_left >= LEN_W'(2));
        push_n    = rd_strobe ? 2'd1 : (push_ok ? 2'd2 : 2'd0);
        pop_n     = pop_ok ? 3'd4 : (wr_strobe ? 3'd1 : 3'd0);
        flush     = busy && stop;
        last_byte = (remaining == LEN_W'(1));
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (accept && (start_len != '0))
                    state_nx = start_dir ? ST_POST : ST_FETCH;
            end
            ST_FETCH: begin
                if (stop)                        state_nx = ST_IDLE;
                else if (rd_strobe && last_byte) state_nx = ST_DRAIN;
            end
            ST_DRAIN: begin
                if (stop)                                  state_nx = ST_IDLE;
                else if (pop_ok && (level == LVL_W'(4)))   state_nx = ST_IDLE;
            end
            ST_POST: begin
                if (stop)                        state_nx = ST_IDLE;
                else if (wr_strobe && last_byte) state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            remaining <= '0;
            host_left <= '0;
            dir_q     <= 1'b0;
            dma_q     <= 1'b0;
            cs_q      <= '0;
            start_ack <= 1'b0;
            start_nak <= 1'b0;
        end else begin
            start_ack <= accept;
            start_nak <= start && busy;
            if (accept) begin
                remaining <= start_len;
                host_left <= start_len;
                dir_q     <= start_dir;
                dma_q     <= start_dma;
                cs_q      <= start_cs;
            end else if (flush) begin
                remaining <= '0;
                host_left <= '0;
            end else begin
                if (rd_strobe || wr_strobe) remaining <= remaining - LEN_W'(1);
                if (push_ok)                host_left <= host_left - LEN_W'(2);
            end
        end
    end
endmodule

// File: rtl/nxe_dma_pace.sv
`timescale 1ns/1ps
module nxe_dma_pace
    import nxe_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int FRAME = 64,
    parameter int LEN_W = 14,
    parameter int LVL_W = $clog2(DEPTH) + 1
) (
    input  nxe_state_e       state,
    input  logic             dma_en,
    input  logic [LVL_W-1:0] level,
    input  logic [LEN_W-1:0] host_left,
    output logic             dma_req
);
    localparam logic [LVL_W-1:0] FR_LVL = LVL_W'(FRAME);
    localparam logic [LEN_W-1:0] FR_LEN = LEN_W'(FRAME);

    logic [LVL_W-1:0] free_cnt;
    logic             rd_frame;
    logic             wr_frame;

    always_comb begin
        free_cnt = LVL_W'(DEPTH) - level;
        rd_frame = ((state == ST_FETCH) || (state == ST_DRAIN)) && (level >= FR_LVL);
        wr_frame = (state == ST_POST) && (free_cnt >= FR_LVL) && (host_left >= FR_LEN);
        dma_req  = dma_en && (rd_frame || wr_frame);
    end
endmodule

// File: rtl/nand_xfer_engine.sv
`timescale 1ns/1ps
module nand_xfer_engine
    import nxe_pkg::*;
#(
    parameter int LEN_W = 14,
    parameter int CS_W  = 3,
    parameter int DEPTH = 64,
    parameter int FRAME = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CS_W-1:0]  start_cs,
    input  logic             start_dma,
    input  logic [LEN_W-1:0] start_len,
    input  logic             start_dir,
    input  logic             stop,
    output logic             start_ack,
    output logic             start_nak,
    output logic             busy,
    output logic [31:0]      status,
    input  logic             host_rd,
    output logic [31:0]      host_rd_data,
    input  logic             host_wr,
    input  logic [15:0]      host_wr_data,
    output logic             dma_req,
    output logic [CS_W-1:0]  nand_cs,
    input  logic             nand_rdy,
    output logic             nand_rd_strobe,
    input  logic [7:0]       nand_rd_data,
    output logic             nand_wr_strobe,
    output logic [7:0]       nand_wr_data
);
    localparam int LVL_W   = $clog2(DEPTH) + 1;
    localparam int CNT_LSB = 24;

    nxe_state_e       state;
    logic [1:0]       push_n;
    logic [2:0]       pop_n;
    logic             flush;
    logic [LEN_W-1:0] remaining;
    logic [LEN_W-1:0] host_left;
    logic             dir_q;
    logic             dma_q;
    logic [LVL_W-1:0] level;
    logic [31:0]      head;
    logic [15:0]      push_data;
    logic [LVL_W-1:0] cnt_field;

    nxe_ctrl #(.LEN_W(LEN_W), .CS_W(CS_W), .DEPTH(DEPTH), .LVL_W(LVL_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .start_cs  (start_cs),
        .start_dma (start_dma),
        .start_len (start_len),
        .start_dir (start_dir),
        .stop      (stop),
        .nand_rdy  (nand_rdy),
        .host_rd   (host_rd),
        .host_wr   (host_wr),
        .level     (level),
        .state     (state),
        .busy      (busy),
        .rd_strobe (nand_rd_strobe),
        .wr_strobe (nand_wr_strobe),
        .push_n    (push_n),
        .pop_n     (pop_n),
        .flush     (flush),
        .remaining (remaining),
        .host_left (host_left),
        .dir_q     (dir_q),
        .dma_q     (dma_q),
        .cs_q      (nand_cs),
        .start_ack (start_ack),
        .start_nak (start_nak)
    );

    nxe_ring #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_ring (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .push_n    (push_n),
        .push_data (push_data),
        .pop_n     (pop_n),
        .head      (head),
        .level     (level)
    );

    nxe_dma_pace #(.DEPTH(DEPTH), .FRAME(FRAME), .LEN_W(LEN_W), .LVL_W(LVL_W)) u_pace (
        .state     (state),
        .dma_en    (dma_q),
        .level     (level),
        .host_left (host_left),
        .dma_req   (dma_req)
    );

    always_comb begin
        push_data    = nand_rd_strobe ? {8'h00, nand_rd_data} : host_wr_data;
        cnt_field    = dir_q ? (LVL_W'(DEPTH) - level) : level;
        host_rd_data = head;
        nand_wr_data = head[7:0];
        status                       = '0;
        status[31]                   = busy;
        status[CNT_LSB +: LVL_W]     = cnt_field;
        status[0 +: LEN_W]           = remaining;
    end
endmodule

// File: rtl/nxe_checker.sv
`timescale 1ns/1ps
module nxe_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        start,
    input logic        stop,
    input logic        busy,
    input logic        start_ack,
    input logic        start_nak,
    input logic [6:0]  cnt,
    input logic [13:0] rem,
    input logic        rd_stb,
    input logic        wr_stb
);
    a_r2_accept_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (start_ack && !start_nak));

    a_r3_reject_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (start && busy) |=> (start_nak && !start_ack));

    a_r3_keep_count: assert property (@(posedge clk) disable iff (!rst_n)
        (start && busy && !stop && !rd_stb && !wr_stb) |=> (rem == $past(rem)));

    a_r5_no_fetch_full: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb |-> (cnt != 7'd64));

    a_r6_no_post_empty: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> (cnt != 7'd64));

    a_r7_count_down: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !stop && (rd_stb || wr_stb)) |=> (rem == 14'($past(rem) - 14'd1)));

    a_r9_stop_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && stop) |=> (!busy && (rem == 14'd0)));

    a_r4_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_stb && wr_stb));
endmodule

bind nand_xfer_engine nxe_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .stop      (stop),
    .busy      (busy),
    .start_ack (start_ack),
    .start_nak (start_nak),
    .cnt       (status[30:24]),
    .rem       (status[13:0]),
    .rd_stb    (nand_rd_strobe),
    .wr_stb    (nand_wr_strobe)
);

// File: tb/nand_xfer_engine_tb.sv
`timescale 1ns/1ps
module nand_xfer_engine_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  start_cs = '0;
    logic        start_dma = 1'b0;
    logic [13:0] start_len = '0;
    logic        start_dir = 1'b0;
    logic        stop = 1'b0;
    logic        start_ack, start_nak, busy, dma_req;
    logic [31:0] status, host_rd_data;
    logic        host_rd = 1'b0;
    logic        host_wr = 1'b0;
    logic [15:0] host_wr_data = '0;
    logic [2:0]  nand_cs;
    logic        nand_rdy = 1'b0;
    logic        nand_rd_strobe, nand_wr_strobe;
    logic [7:0]  nand_rd_data, nand_wr_data;

    int nchecks = 0;
    int nerrs   = 0;
    int rd_idx  = 0;
    int wcnt    = 0;
    logic [7:0] wlog [256];

    always #5 clk = ~clk;

    nand_xfer_engine u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .start_cs(start_cs),
        .start_dma(start_dma), .start_len(start_len), .start_dir(start_dir),
        .stop(stop), .start_ack(start_ack), .start_nak(start_nak), .busy(busy),
        .status(status), .host_rd(host_rd), .host_rd_data(host_rd_data),
        .host_wr(host_wr), .host_wr_data(host_wr_data), .dma_req(dma_req),
        .nand_cs(nand_cs), .nand_rdy(nand_rdy), .nand_rd_strobe(nand_rd_strobe),
        .nand_rd_data(nand_rd_data), .nand_wr_strobe(nand_wr_strobe),
        .nand_wr_data(nand_wr_data)
    );

    function automatic logic [7:0] pat(input int i);
        return 8'((i * 37 + 11) & 255);
    endfunction

    function automatic logic [31:0] word_at(input int base, input int k);
        return {pat(base + 4*k + 3), pat(base + 4*k + 2), pat(base + 4*k + 1), pat(base + 4*k)};
    endfunction

    assign nand_rd_data = pat(rd_idx);

    always @(posedge clk) begin
        if (nand_rd_strobe) rd_idx <= rd_idx + 1;
        if (nand_wr_strobe) begin
            wlog[wcnt & 255] <= nand_wr_data;
            wcnt <= wcnt + 1;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchecks++;
        if (act !== exp) begin
            nerrs++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_start(input logic [2:0] cs, input logic dma, input int len, input logic dir);
        start = 1'b1; start_cs = cs; start_dma = dma; start_len = 14'(len); start_dir = dir;
        tick();
        start = 1'b0;
    endtask

    task automatic do_stop();
        stop = 1'b1;
        tick();
        stop = 1'b0;
    endtask

    task automatic pop_check(input string req, input logic [31:0] exp);
        host_rd = 1'b1;
        check(req, host_rd_data, exp);
        tick();
        host_rd = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 busy", 32'(busy), 0);
        check("R1 status", status, 0);
        check("R1 dma_req", 32'(dma_req), 0);
        check("R1 strobes", 32'({nand_rd_strobe, nand_wr_strobe}), 0);
    endtask

    task automatic t_zero_len();
        do_start(3'd1, 1'b0, 0, 1'b0);
        check("R2 zero-length ack", 32'(start_ack), 1);
        check("R2 zero-length stays idle", 32'(busy), 0);
    endtask

    task automatic t_read_basic();
        int base;
        nand_rdy = 1'b1;
        base = rd_idx;
        do_start(3'd5, 1'b0, 16, 1'b0);
        check("R2 ack", 32'(start_ack), 1);
        check("R2 busy", 32'(busy), 1);
        check("R2 remaining", 32'(status[13:0]), 16);
        check("R11 cs", 32'(nand_cs), 5);
        tick();
        check("R7 remaining after one byte", 32'(status[13:0]), 15);
        check("R7 held count", 32'(status[30:24]), 1);
        check("R7 busy bit", 32'(status[31]), 1);
        repeat (15) tick();
        check("R7 remaining done", 32'(status[13:0]), 0);
        check("R8 busy while FIFO holds data", 32'(busy), 1);
        for (int k = 0; k < 4; k++) pop_check("R4 word data", word_at(base, k));
        check("R8 busy clears after drain", 32'(busy), 0);
        check("R4 no overfetch", 32'(rd_idx - base), 16);
        nand_rdy = 1'b0;
    endtask

    task automatic t_partial();
        int base;
        nand_rdy = 1'b1;
        base = rd_idx;
        do_start(3'd2, 1'b0, 6, 1'b0);
        repeat (6) tick();
        check("R4 six held", 32'(status[30:24]), 6);
        pop_check("R4 first word", word_at(base, 0));
        check("R4 two left", 32'(status[30:24]), 2);
        host_rd = 1'b1;
        tick();
        host_rd = 1'b0;
        check("R4 short pop ignored", 32'(status[30:24]), 2);
        check("R8 busy with leftover", 32'(busy), 1);
        do_stop();
        check("R9 idle after stop", 32'(busy), 0);
        check("R9 flushed", status, 0);
        nand_rdy = 1'b0;
    endtask

    task automatic t_full_stall();
        int base;
        nand_rdy = 1'b1;
        base = rd_idx;
        do_start(3'd3, 1'b0, 100, 1'b0);
        repeat (70) tick();
        check("R5 FIFO full", 32'(status[30:24]), 64);
        check("R5 remaining held", 32'(status[13:0]), 36);
        check("R5 no strobe when full", 32'(nand_rd_strobe), 0);
        check("R10 no dma_req without flag", 32'(dma_req), 0);
        do_start(3'd6, 1'b0, 5, 1'b1);
        check("R3 nak", 32'(start_nak), 1);
        check("R3 no ack", 32'(start_ack), 0);
        check("R3 remaining unchanged", 32'(status[13:0]), 36);
        check("R11 cs kept", 32'(nand_cs), 3);
        pop_check("R4 word after stall", word_at(base, 0));
        check("R5 level after pop", 32'(status[30:24]), 60);
        do_stop();
        check("R9 stop mid-read", 32'({status[31], status[13:0]}), 0);
        nand_rdy = 1'b0;
    endtask

    task automatic t_write();
        int wb;
        wb = wcnt;
        nand_rdy = 1'b1;
        do_start(3'd1, 1'b0, 6, 1'b1);
        check("R7 free space write", 32'(status[30:24]), 64);
        repeat (3) tick();
        check("R6 no write from empty FIFO", 32'(status[13:0]), 6);
        check("R6 strobe low when empty", 32'(nand_wr_strobe), 0);
        nand_rdy = 1'b0;
        host_wr = 1'b1;
        host_wr_data = 16'hA1B2; tick();
        host_wr_data = 16'hC3D4; tick();
        host_wr_data = 16'hE5F6; tick();
        check("R7 free after three", 32'(status[30:24]), 58);
        host_wr_data = 16'h9988; tick();
        host_wr = 1'b0;
        check("R6 extra halfword ignored", 32'(status[30:24]), 58);
        check("R10 no dma_req without flag", 32'(dma_req), 0);
        nand_rdy = 1'b1;
        repeat (6) tick();
        check("R8 idle after last write", 32'(busy), 0);
        check("R6 byte count", 32'(wcnt - wb), 6);
        check("R6 order", {wlog[wb & 255], wlog[(wb+1) & 255], wlog[(wb+2) & 255], wlog[(wb+3) & 255]},
              32'hB2A1D4C3);
        check("R6 order tail", 32'({wlog[(wb+4) & 255], wlog[(wb+5) & 255]}), 32'hF6E5);
        nand_rdy = 1'b0;
    endtask

    task automatic t_dma_read();
        int base, n;
        nand_rdy = 1'b1;
        base = rd_idx;
        do_start(3'd0, 1'b1, 128, 1'b0);
        check("R10 no request yet", 32'(dma_req), 0);
        for (int f = 0; f < 2; f++) begin
            n = 0;
            while (!dma_req && n < 200) begin tick(); n++; end
            check("R10 frame request", 32'(dma_req), 1);
            check("R10 full frame held", 32'(status[30:24]), 64);
            for (int k = 0; k < 16; k++) begin
                pop_check("R10 frame data", word_at(base, 16*f + k));
                if (k == 0) check("R10 request drops", 32'(dma_req), 0);
            end
        end
        check("R8 idle after DMA read", 32'(busy), 0);
        nand_rdy = 1'b0;
    endtask

    task automatic t_dma_write();
        do_start(3'd4, 1'b1, 64, 1'b1);
        check("R10 write frame request", 32'(dma_req), 1);
        host_wr = 1'b1; host_wr_data = 16'h1234;
        tick();
        host_wr = 1'b0;
        check("R10 request drops below frame", 32'(dma_req), 0);
        do_stop();
        check("R9 stop write", 32'({busy, dma_req}), 0);
        check("R9 free restored", 32'(status[30:24]), 64);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_zero_len();
        t_read_basic();
        t_partial();
        t_full_stall();
        t_write();
        t_dma_read();
        t_dma_write();
        $display("CHECKS %0d ERRORS %0d", nchecks, nerrs);
        $finish;
    end

    initial begin
        #1000000;
        nchecks++;
        nerrs++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", nchecks, nerrs);
        $finish;
    end
endmodule